// File: doc/BRIEF.md
# Egress Byte-Grant Scheduler

This block sits at one egress port of a multi-port packet forwarder. Every ingress port that holds traffic for this egress sends it a request message with two byte counts: high-priority bytes waiting and low-priority bytes waiting. The scheduler keeps only the newest request from each ingress. It tracks how much of its output buffer is free, picks one requesting ingress at a time in round-robin order, and answers it with a response that grants a byte budget for each priority.

Once a response has gone out, the scheduler waits. The granted ingress sends a burst of payload, and the burst ends with a fresh request from that same ingress. That trailing request closes the exchange, returns any part of the grant that was not used, and is stored like any other request. Burst bytes that land in the buffer are reported on one input. Bytes that leave the buffer toward the line side are reported on another.

The buffer size, the number of ingress ports and the width of the byte counters are parameters. The default buffer holds 15360 bytes, which is about ten full-size Ethernet frames.

Top module: `egress_grant_sched`

## Requirements
- R1: After reset no response is valid, no request is pending, the buffer counts as empty and ingress 0 is the first candidate of the round-robin scan.
- R2: When several ingresses are pending, the scan starts at the ingress after the one granted last (wrapping from N-1 to 0), and the first pending ingress it meets is chosen.
- R3: A response is a one-cycle pulse on `rsp_vld` carrying the chosen ingress index on `rsp_ing`, the high-priority grant on `rsp_hi` and the low-priority grant on `rsp_lo`.
- R4: Grants are strict priority. `rsp_hi` = min(stored high count, free space) and `rsp_lo` = min(stored low count, free space − `rsp_hi`).
- R5: After a response, no other response is issued until a request arrives from the ingress that was granted. Requests from other ingresses do not end the wait.
- R6: A request whose two counts are both zero leaves that ingress with nothing pending, and the scan skips it.
- R7: Free space = capacity − stored bytes − open grant, floored at zero. A grant is charged in full when issued. A burst moves its bytes from the open grant to the stored count. A drain lowers the stored count (floored at zero). The trailing request returns whatever remains of the open grant. The stored count is capped at the capacity.
- R8: A pending request is still answered when free space is zero. Both grants are then zero.
- R9: A new request from an ingress overwrites the counts held for it, even while a response is outstanding. If a write and a grant hit the same ingress in one cycle, the write wins and that ingress stays pending.
- R10: A request sampled at clock edge k can be granted at edge k+1 at the earliest. `rsp_vld` is then high for the cycle that follows edge k+1. Burst, drain and trailing request inputs sampled at one edge all affect the free space used from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_vld | input | 1 | A request message is present this cycle |
| req_ing | input | IDX_W | Ingress that sent the request |
| req_hi | input | CNT_W | High-priority bytes waiting at that ingress |
| req_lo | input | CNT_W | Low-priority bytes waiting at that ingress |
| burst_vld | input | 1 | Burst bytes were written into the output buffer |
| burst_bytes | input | CNT_W | Number of burst bytes written |
| drain_vld | input | 1 | Bytes left the output buffer toward the line side |
| drain_bytes | input | CNT_W | Number of bytes drained |
| rsp_vld | output | 1 | Response pulse |
| rsp_ing | output | IDX_W | Ingress the response is addressed to |
| rsp_hi | output | CNT_W | High-priority byte grant |
| rsp_lo | output | CNT_W | Low-priority byte grant |

## Verification
The events most likely to interact are a trailing request, a burst arrival and a buffer drain landing in the same cycle. All three change free space, and the trailing request also reopens arbitration. The bench drives a trailing request together with a drain, and separately together with burst bytes. It then checks that the next grant is sized from the combined free space. A long random phase mixes requests, bursts and drains in every combination, and a cycle-by-cycle behavioural model judges each response pulse, ingress and grant.

// File: rtl/egs_pkg.sv
package egs_pkg;
  typedef enum logic {
    SCH_IDLE = 1'b0,
    SCH_WAIT = 1'b1
  } sched_st_e;
endpackage

// File: rtl/egs_req_table.sv
module egs_req_table #(
  parameter int N_ING = 4,
  parameter int CNT_W = 16,
  localparam int IDX_W = (N_ING > 1) ? $clog2(N_ING) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_vld,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [CNT_W-1:0]            wr_hi,
  input  logic [CNT_W-1:0]            wr_lo,
  input  logic                        clr_vld,
  input  logic [IDX_W-1:0]            clr_idx,
  output logic [N_ING-1:0]            pend,
  output logic [N_ING-1:0][CNT_W-1:0] hi_all,
  output logic [N_ING-1:0][CNT_W-1:0] lo_all
);
  // one entry per ingress; a write overrides a clear in the same cycle
  for (genvar i = 0; i < N_ING; i++) begin : g_ent
    logic wr_en, clr_en;
    logic pend_d;
    assign wr_en  = wr_vld && (wr_idx == IDX_W'(i));
    assign clr_en = clr_vld && (clr_idx == IDX_W'(i));

    always_comb begin
      pend_d = pend[i];
      if (wr_en)       pend_d = (wr_hi != '0) || (wr_lo != '0);
      else if (clr_en) pend_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i]   <= 1'b0;
        hi_all[i] <= '0;
        lo_all[i] <= '0;
      end else begin
        pend[i] <= pend_d;
        if (wr_en) begin
          hi_all[i] <= wr_hi;
          lo_all[i] <= wr_lo;
        end
      end
    end
  end
endmodule

// File: rtl/egs_rr_pick.sv
module egs_rr_pick #(
  parameter int N_ING = 4,
  localparam int IDX_W = (N_ING > 1) ? $clog2(N_ING) : 1
) (
  input  logic [N_ING-1:0] pend,
  input  logic [IDX_W-1:0] last,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // scan starts one past the last granted ingress and wraps
  always_comb begin
    any = 1'b0;
    idx = last;
    for (int k = 1; k <= N_ING; k++) begin
      int c;
      c = int'(last) + k;
      if (c >= N_ING) c = c - N_ING;
      if (!any && pend[c]) begin
        any = 1'b1;
        idx = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/egs_space.sv
module egs_space #(
  parameter int CNT_W     = 16,
  parameter int CAP_BYTES = 15360,
  localparam int WW = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_vld,
  input  logic [CNT_W-1:0] burst_bytes,
  input  logic             drain_vld,
  input  logic [CNT_W-1:0] drain_bytes,
  input  logic             charge_vld,
  input  logic [CNT_W-1:0] charge_bytes,
  input  logic             release_vld,
  output logic [CNT_W-1:0] free_bytes
);
  localparam logic [WW-1:0] CAP_X = WW'(CAP_BYTES);

  logic [CNT_W-1:0] stored_q, owed_q;
  logic [CNT_W-1:0] stored_d, owed_d;
  logic [WW-1:0]    sum_w, drn_w, st_w, brs_w, tot_w;

  always_comb begin
    brs_w = burst_vld ? WW'(burst_bytes) : '0;
    drn_w = drain_vld ? WW'(drain_bytes) : '0;
    sum_w = WW'(stored_q) + brs_w;
    st_w  = (drn_w > sum_w) ? '0 : (sum_w - drn_w);
    if (st_w > CAP_X) st_w = CAP_X;
    stored_d = CNT_W'(st_w);

    owed_d = owed_q;
    if (release_vld)    owed_d = '0;
    else if (burst_vld) owed_d = (burst_bytes >= owed_q) ? '0 : (owed_q - burst_bytes);
    if (charge_vld)     owed_d = charge_bytes;

    tot_w      = WW'(stored_q) + WW'(owed_q);
    free_bytes = (tot_w >= CAP_X) ? '0 : CNT_W'(CAP_X - tot_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_q <= '0;
      owed_q   <= '0;
    end else begin
      stored_q <= stored_d;
      owed_q   <= owed_d;
    end
  end
endmodule

// File: rtl/egress_grant_sched.sv
module egress_grant_sched #(
  parameter int N_ING     = 4,
  parameter int CNT_W     = 16,
  parameter int CAP_BYTES = 15360,
  localparam int IDX_W = (N_ING > 1) ? $clog2(N_ING) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [IDX_W-1:0] req_ing,
  input  logic [CNT_W-1:0] req_hi,
  input  logic [CNT_W-1:0] req_lo,
  input  logic             burst_vld,
  input  logic [CNT_W-1:0] burst_bytes,
  input  logic             drain_vld,
  input  logic [CNT_W-1:0] drain_bytes,
  output logic             rsp_vld,
  output logic [IDX_W-1:0] rsp_ing,
  output logic [CNT_W-1:0] rsp_hi,
  output logic [CNT_W-1:0] rsp_lo
);
  import egs_pkg::*;

  sched_st_e               st_q, st_d;
  logic [IDX_W-1:0]        cur_q, cur_d;
  logic [IDX_W-1:0]        ptr_q, ptr_d;
  logic [N_ING-1:0]        pend;
  logic [N_ING-1:0][CNT_W-1:0] hi_all, lo_all;
  logic                    any, fire, release_vld;
  logic [IDX_W-1:0]        sel_idx;
  logic [CNT_W-1:0]        free_bytes, sel_hi, sel_lo, g_hi, g_lo, rem, grant_sum;

  egs_req_table #(.N_ING(N_ING), .CNT_W(CNT_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_vld(req_vld), .wr_idx(req_ing), .wr_hi(req_hi), .wr_lo(req_lo),
    .clr_vld(fire), .clr_idx(sel_idx),
    .pend(pend), .hi_all(hi_all), .lo_all(lo_all)
  );

  egs_rr_pick #(.N_ING(N_ING)) u_pick (
    .pend(pend), .last(ptr_q), .any(any), .idx(sel_idx)
  );

  egs_space #(.CNT_W(CNT_W), .CAP_BYTES(CAP_BYTES)) u_space (
    .clk(clk), .rst_n(rst_n),
    .burst_vld(burst_vld), .burst_bytes(burst_bytes),
    .drain_vld(drain_vld), .drain_bytes(drain_bytes),
    .charge_vld(fire), .charge_bytes(grant_sum),
    .release_vld(release_vld), .free_bytes(free_bytes)
  );

  // strict-priority grant sizing
  always_comb begin
    sel_hi    = hi_all[sel_idx];
    sel_lo    = lo_all[sel_idx];
    g_hi      = (sel_hi < free_bytes) ? sel_hi : free_bytes;
    rem       = free_bytes - g_hi;
    g_lo      = (sel_lo < rem) ? sel_lo : rem;
    grant_sum = g_hi + g_lo;
  end

  assign fire        = (st_q == SCH_IDLE) && any;
  assign release_vld = (st_q == SCH_WAIT) && req_vld && (req_ing == cur_q);

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    ptr_d = ptr_q;
    if (fire) begin
      st_d  = SCH_WAIT;
      cur_d = sel_idx;
      ptr_d = sel_idx;
    end else if (release_vld) begin
      st_d  = SCH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SCH_IDLE;
      cur_q   <= '0;
      ptr_q   <= IDX_W'(N_ING - 1);
      rsp_vld <= 1'b0;
      rsp_ing <= '0;
      rsp_hi  <= '0;
      rsp_lo  <= '0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      ptr_q   <= ptr_d;
      rsp_vld <= fire;
      if (fire) begin
        rsp_ing <= sel_idx;
        rsp_hi  <= g_hi;
        rsp_lo  <= g_lo;
      end
    end
  end
endmodule

// File: rtl/egress_grant_sched_chk.sv
module egress_grant_sched_chk #(
  parameter int N_ING     = 4,
  parameter int CNT_W     = 16,
  parameter int CAP_BYTES = 15360,
  localparam int IDX_W = (N_ING > 1) ? $clog2(N_ING) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_vld,
  input logic [IDX_W-1:0] req_ing,
  input logic [CNT_W-1:0] req_hi,
  input logic [CNT_W-1:0] req_lo,
  input logic             rsp_vld,
  input logic [IDX_W-1:0] rsp_ing,
  input logic [CNT_W-1:0] rsp_hi,
  input logic [CNT_W-1:0] rsp_lo,
  input logic [CNT_W-1:0] free_bytes
);
  logic [CNT_W-1:0] sh_hi [N_ING];
  logic [CNT_W-1:0] sh_lo [N_ING];
  logic [CNT_W-1:0] sh_hi_d [N_ING];
  logic [CNT_W-1:0] sh_lo_d [N_ING];
  logic             open_q;
  logic [IDX_W-1:0] open_ing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ING; i++) begin
        sh_hi[i] <= '0; sh_lo[i] <= '0; sh_hi_d[i] <= '0; sh_lo_d[i] <= '0;
      end
      open_q   <= 1'b0;
      open_ing <= '0;
    end else begin
      for (int i = 0; i < N_ING; i++) begin
        sh_hi_d[i] <= sh_hi[i];
        sh_lo_d[i] <= sh_lo[i];
        if (req_vld && req_ing == IDX_W'(i)) begin
          sh_hi[i] <= req_hi;
          sh_lo[i] <= req_lo;
        end
      end
      if (rsp_vld) begin
        open_q   <= !(req_vld && req_ing == rsp_ing);
        open_ing <= rsp_ing;
      end else if (open_q && req_vld && req_ing == open_ing) begin
        open_q   <= 1'b0;
      end
    end
  end

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> !open_q);                                           // R5
  AST_GRANT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> ({1'b0, rsp_hi} + {1'b0, rsp_lo}) <= {1'b0, $past(free_bytes)}); // R7
  AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_lo != '0) |-> rsp_hi == sh_hi_d[rsp_ing]);     // R4
  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> rsp_lo <= sh_lo_d[rsp_ing]);                       // R4
  AST_NOT_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> (sh_hi_d[rsp_ing] != '0 || sh_lo_d[rsp_ing] != '0)); // R6
endmodule

bind egress_grant_sched egress_grant_sched_chk #(
  .N_ING(N_ING), .CNT_W(CNT_W), .CAP_BYTES(CAP_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_vld(req_vld), .req_ing(req_ing), .req_hi(req_hi), .req_lo(req_lo),
  .rsp_vld(rsp_vld), .rsp_ing(rsp_ing), .rsp_hi(rsp_hi), .rsp_lo(rsp_lo),
  .free_bytes(free_bytes)
);

// File: tb/tb_egress_grant_sched.sv
module tb_egress_grant_sched;
  localparam int N   = 4;
  localparam int CW  = 16;
  localparam int CAP = 15360;
  localparam int IW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_vld = 1'b0;
  logic [IW-1:0] req_ing = '0;
  logic [CW-1:0] req_hi = '0, req_lo = '0;
  logic          burst_vld = 1'b0;
  logic [CW-1:0] burst_bytes = '0;
  logic          drain_vld = 1'b0;
  logic [CW-1:0] drain_bytes = '0;
  logic          rsp_vld;
  logic [IW-1:0] rsp_ing;
  logic [CW-1:0] rsp_hi, rsp_lo;

  always #2 clk = ~clk;   // 250 MHz

  egress_grant_sched #(.N_ING(N), .CNT_W(CW), .CAP_BYTES(CAP)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_vld(req_vld), .req_ing(req_ing), .req_hi(req_hi), .req_lo(req_lo),
    .burst_vld(burst_vld), .burst_bytes(burst_bytes),
    .drain_vld(drain_vld), .drain_bytes(drain_bytes),
    .rsp_vld(rsp_vld), .rsp_ing(rsp_ing), .rsp_hi(rsp_hi), .rsp_lo(rsp_lo)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_hi[N], m_lo[N];
  bit m_pend[N];
  int m_ptr, m_bing, m_st, m_ow;
  bit m_busy;
  bit m_rv;
  int m_ri, m_rh, m_rl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_hi[i]) begin m_hi[i] = 0; m_lo[i] = 0; m_pend[i] = 0; end
      m_ptr = N - 1; m_bing = 0; m_st = 0; m_ow = 0; m_busy = 0;
      m_rv = 0; m_ri = 0; m_rh = 0; m_rl = 0;
    end else begin
      int fr, sel, gh, gl, t;
      bit fire, rel;
      fr = CAP - m_st - m_ow;
      if (fr < 0) fr = 0;
      fire = 0; sel = 0; gh = 0; gl = 0;
      if (!m_busy)
        for (int k = 1; k <= N; k++) begin
          int c;
          c = (m_ptr + k) % N;
          if (!fire && m_pend[c]) begin fire = 1; sel = c; end
        end
      if (fire) begin
        gh = (m_hi[sel] < fr) ? m_hi[sel] : fr;
        gl = (m_lo[sel] < fr - gh) ? m_lo[sel] : fr - gh;
      end
      rel = m_busy && req_vld && (int'(req_ing) == m_bing);
      t = m_st + (burst_vld ? int'(burst_bytes) : 0) - (drain_vld ? int'(drain_bytes) : 0);
      if (t < 0) t = 0;
      if (t > CAP) t = CAP;
      m_st = t;
      if (rel) m_ow = 0;
      else if (burst_vld) begin
        m_ow = m_ow - int'(burst_bytes);
        if (m_ow < 0) m_ow = 0;
      end
      if (fire) m_ow = gh + gl;
      if (fire) m_pend[sel] = 0;
      if (req_vld) begin
        m_hi[req_ing] = req_hi;
        m_lo[req_ing] = req_lo;
        m_pend[req_ing] = (req_hi != 0) || (req_lo != 0);
      end
      if (fire) begin m_busy = 1; m_bing = sel; m_ptr = sel; end
      else if (rel) m_busy = 0;
      m_rv = fire;
      if (fire) begin m_ri = sel; m_rh = gh; m_rl = gl; end
    end
  end

  // per-cycle comparison and response log, away from the active edge
  int lg_i[$], lg_h[$], lg_l[$];
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rsp_vld == m_rv, "R10 R5 response pulse", rsp_vld, m_rv);
      if (m_rv && rsp_vld) begin
        chk(int'(rsp_ing) == m_ri, "R2 R3 granted ingress", rsp_ing, m_ri);
        chk(int'(rsp_hi) == m_rh, "R4 R7 high grant", rsp_hi, m_rh);
        chk(int'(rsp_lo) == m_rl, "R4 R7 low grant", rsp_lo, m_rl);
      end
      if (rsp_vld) begin
        lg_i.push_back(rsp_ing); lg_h.push_back(rsp_hi); lg_l.push_back(rsp_lo);
      end
    end
  end

  task automatic step(input bit rv, input int ri, input int rh, input int rl,
                      input bit bv, input int bb, input bit dv, input int db);
    @(negedge clk);
    req_vld = rv; req_ing = IW'(ri); req_hi = CW'(rh); req_lo = CW'(rl);
    burst_vld = bv; burst_bytes = CW'(bb); drain_vld = dv; drain_bytes = CW'(db);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_entry(input int e, input string tag, input int ei, input int eh, input int el);
    if (lg_i.size() <= e) begin
      chk(0, tag, lg_i.size(), e + 1);
    end else begin
      chk(lg_i[e] == ei, tag, lg_i[e], ei);
      chk(lg_h[e] == eh, tag, lg_h[e], eh);
      chk(lg_l[e] == el, tag, lg_l[e], el);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_vld == 1'b0, "R1 no response in reset", rsp_vld, 0);
    rst_n = 1'b1;
    idle(3);
    chk(lg_i.size() == 0, "R1 nothing pending after reset", lg_i.size(), 0);

    step(1, 2, 1000, 500, 0, 0, 0, 0); idle(4);
    expect_entry(0, "R3 first grant", 2, 1000, 500);
    step(1, 0, 100, 100, 0, 0, 0, 0);
    step(1, 1, 20000, 10, 0, 0, 0, 0); idle(4);
    chk(lg_i.size() == 1, "R5 other ingress does not release", lg_i.size(), 1);
    step(0, 0, 0, 0, 1, 1200, 0, 0);
    step(1, 2, 0, 0, 0, 0, 0, 0); idle(4);
    expect_entry(1, "R2 wrap past last granted", 0, 100, 100);
    step(0, 0, 0, 0, 1, 200, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0); idle(4);
    expect_entry(2, "R4 high takes all free space", 1, 13960, 0);
    step(1, 3, 50, 50, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 13960, 0, 0);
    step(1, 1, 6040, 10, 0, 0, 0, 0); idle(4);
    expect_entry(3, "R8 R6 zero free, null ingress skipped", 3, 0, 0);
    step(1, 3, 50, 50, 0, 0, 0, 0); idle(4);
    expect_entry(4, "R8 zero grant again", 1, 0, 0);
    step(1, 1, 6040, 10, 0, 0, 1, 5000); idle(4);
    expect_entry(5, "R7 trailer with drain same cycle", 3, 50, 50);
    step(1, 3, 0, 0, 1, 100, 0, 0); idle(4);
    expect_entry(6, "R7 trailer with burst same cycle", 1, 4900, 0);
    step(1, 0, 10, 20, 0, 0, 0, 0);
    step(1, 0, 30, 40, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 1, 10000); idle(4);
    expect_entry(7, "R9 latest request overwrites", 0, 30, 40);
    chk(lg_i.size() == 8, "R6 no grant to null ingresses", lg_i.size(), 8);

    for (int c = 0; c < 6000; c++) begin
      bit rv, bv, dv;
      int ri, rh, rl;
      rv = ($urandom_range(0, 99) < 30);
      ri = $urandom_range(0, N - 1);
      rh = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(0, 6000);
      rl = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(0, 6000);
      bv = ($urandom_range(0, 99) < 20);
      dv = ($urandom_range(0, 99) < 25);
      step(rv, ri, rh, rl, bv, $urandom_range(0, 3000), dv, $urandom_range(0, 3000));
    end
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule